// File: doc/BRIEF.md
# Read-Address Command Sequence Detector

This block snoops the read cycles of an asynchronous SRAM-style bus, sampled on a synchronous system clock. It looks for a fixed series of six read addresses that carries a nonvolatile control command. Five fixed addresses come first, in a set order. The sixth address then picks one of four commands: a nonvolatile store, a recall, turning automatic store on, or turning it off. On a recognised command the block raises a one-clock pulse on the matching output. Any write, or any read that breaks the series, silently restarts the match. The block never stalls or alters ordinary reads; it only watches them.

An automatic-store status flag holds the last on/off setting. The block also tells the data-bus drivers when to float. The bus floats while the chip is deselected or the output enable is high. It also floats from a store or recall command until the chip is next deselected.

Top module: `nv_cmd_seq_det`

## Requirements
- R1: After reset all four command pulses are 0, `as_enabled_o` is 1, and the match pointer is empty.
- R2: A read cycle is counted once on a sampled clock where `ce_ni`=0 and `we_ni`=1 and at least one of these holds: `ce_ni` was 1 on the previous sample, `we_ni` was 0 on the previous sample, or `addr_i[15:0]` differs from the previous sample. A read held with an unchanged address counts once.
- R3: The first five counted reads must carry, in this order, the addresses 0x4E38, 0xB1C7, 0x83E0, 0x7C1F and 0x703F.
- R4: If the sixth counted read has address 0x8FC0, `store_o` pulses. If it has address 0x4C63, `recall_o` pulses. The pulse comes in the clock cycle after the sample that counted that read.
- R5: A sixth address of 0x4B46 pulses `as_en_o` and sets `as_enabled_o` to 1. A sixth address of 0x8B45 pulses `as_dis_o` and clears `as_enabled_o`. The status changes in the same cycle as the pulse.
- R6: `addr_i[16]` plays no part in matching or in read-cycle counting.
- R7: Any sampled write (`ce_ni`=0, `we_ni`=0) empties the match pointer, so no command can follow from the reads before it.
- R8: A counted read that does not match the expected address restarts the match. The pointer goes to step one if that address is 0x4E38, and to empty otherwise.
- R9: Each command output is high for exactly one clock, and at most one of the four is high at any time.
- R10: `dq_hiz_o` = `ce_ni` | `oe_ni` | hold. Hold is set together with a store or recall pulse and is cleared on the first sample with `ce_ni`=1. The automatic-store commands never set hold.
- R11: A sixth counted read whose address is not one of the four command codes gives no pulse and restarts the match as in R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_ni | input | 1 | Bus chip enable, active low |
| we_ni | input | 1 | Bus write enable, active low |
| oe_ni | input | 1 | Bus output enable, active low |
| addr_i | input | 17 | Bus address |
| store_o | output | 1 | Store command pulse |
| recall_o | output | 1 | Recall command pulse |
| as_en_o | output | 1 | Automatic-store enable pulse |
| as_dis_o | output | 1 | Automatic-store disable pulse |
| as_enabled_o | output | 1 | Automatic-store setting |
| dq_hiz_o | output | 1 | Data bus should float |

## Verification
The bench goes after the read-counting rule. One test holds an address with chip enable low for several clocks. A detector that counted it twice would step past the pattern and miss the command. Other tests break a sequence with a write, with a wrong address, and with a stray 0x4E38 in mid-sequence. A design that failed to clear or restart its pointer would give false commands or miss real ones. Sequences with address bit 16 set catch a decoder that compares all 17 bits. Random traffic full of near-miss addresses checks that the float hold is set only by store and recall, and is cleared only by deselect.

// File: rtl/nv_seq_pkg.sv
package nv_seq_pkg;
  localparam int KEY_W   = 16;
  localparam int SEQ_LEN = 6;
  localparam int PTR_W   = $clog2(SEQ_LEN);

  typedef enum logic [2:0] {
    CMD_NONE, CMD_STORE, CMD_RECALL, CMD_AS_ON, CMD_AS_OFF
  } nv_cmd_e;

  function automatic logic [KEY_W-1:0] seq_key(input logic [PTR_W-1:0] idx);
    case (idx)
      3'd0:    seq_key = 16'h4E38;
      3'd1:    seq_key = 16'hB1C7;
      3'd2:    seq_key = 16'h83E0;
      3'd3:    seq_key = 16'h7C1F;
      default: seq_key = 16'h703F;
    endcase
  endfunction

  function automatic nv_cmd_e key_to_cmd(input logic [KEY_W-1:0] key);
    case (key)
      16'h8FC0: key_to_cmd = CMD_STORE;
      16'h4C63: key_to_cmd = CMD_RECALL;
      16'h4B46: key_to_cmd = CMD_AS_ON;
      16'h8B45: key_to_cmd = CMD_AS_OFF;
      default:  key_to_cmd = CMD_NONE;
    endcase
  endfunction
endpackage

// File: rtl/nv_cyc_det.sv
module nv_cyc_det
  import nv_seq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ce_ni,
  input  logic             we_ni,
  input  logic [KEY_W-1:0] key_i,
  output logic             rd_evt_o,
  output logic             wr_o
);
  logic             ce_q, we_q;
  logic [KEY_W-1:0] key_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_q  <= 1'b1;
      we_q  <= 1'b1;
      key_q <= '0;
    end else begin
      ce_q  <= ce_ni;
      we_q  <= we_ni;
      key_q <= key_i;
    end
  end

  // new read: fresh select, end of a write, or a new address while selected
  assign rd_evt_o = !ce_ni && we_ni && (ce_q || !we_q || (key_i != key_q));
  assign wr_o     = !ce_ni && !we_ni;
endmodule

// File: rtl/nv_seq_match.sv
module nv_seq_match
  import nv_seq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_evt_i,
  input  logic             wr_i,
  input  logic [KEY_W-1:0] key_i,
  output nv_cmd_e          cmd_o
);
  logic [PTR_W-1:0] step_q, step_d, restart;

  assign restart = (key_i == seq_key('0)) ? PTR_W'(1) : '0;

  always_comb begin
    step_d = step_q;
    cmd_o  = CMD_NONE;
    if (wr_i) begin
      step_d = '0;
    end else if (rd_evt_i) begin
      if (step_q == PTR_W'(SEQ_LEN - 1)) begin
        cmd_o  = key_to_cmd(key_i);
        step_d = restart;
      end else if (key_i == seq_key(step_q)) begin
        step_d = step_q + PTR_W'(1);
      end else begin
        step_d = restart;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) step_q <= '0;
    else         step_q <= step_d;
  end
endmodule

// File: rtl/nv_cmd_out.sv
module nv_cmd_out
  import nv_seq_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  nv_cmd_e cmd_i,
  input  logic    ce_ni,
  input  logic    oe_ni,
  output logic    store_o,
  output logic    recall_o,
  output logic    as_en_o,
  output logic    as_dis_o,
  output logic    as_enabled_o,
  output logic    dq_hiz_o
);
  logic hold_q;
  logic nv_cmd;

  assign nv_cmd = (cmd_i == CMD_STORE) || (cmd_i == CMD_RECALL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      store_o      <= 1'b0;
      recall_o     <= 1'b0;
      as_en_o      <= 1'b0;
      as_dis_o     <= 1'b0;
      as_enabled_o <= 1'b1;
      hold_q       <= 1'b0;
    end else begin
      store_o  <= cmd_i == CMD_STORE;
      recall_o <= cmd_i == CMD_RECALL;
      as_en_o  <= cmd_i == CMD_AS_ON;
      as_dis_o <= cmd_i == CMD_AS_OFF;
      if (cmd_i == CMD_AS_ON)       as_enabled_o <= 1'b1;
      else if (cmd_i == CMD_AS_OFF) as_enabled_o <= 1'b0;
      // float held from store/recall until the next deselect
      if (nv_cmd)     hold_q <= 1'b1;
      else if (ce_ni) hold_q <= 1'b0;
    end
  end

  assign dq_hiz_o = ce_ni | oe_ni | hold_q;
endmodule

// File: rtl/nv_cmd_seq_det.sv
module nv_cmd_seq_det
  import nv_seq_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              store_o,
  output logic              recall_o,
  output logic              as_en_o,
  output logic              as_dis_o,
  output logic              as_enabled_o,
  output logic              dq_hiz_o
);
  logic [KEY_W-1:0]        key;
  logic [ADDR_W-KEY_W-1:0] unused_hi;
  logic                    rd_evt, wr;
  nv_cmd_e                 cmd;

  assign key       = addr_i[KEY_W-1:0];
  assign unused_hi = addr_i[ADDR_W-1:KEY_W];

  nv_cyc_det u_cyc (
    .clk_i, .rst_ni, .ce_ni, .we_ni,
    .key_i(key), .rd_evt_o(rd_evt), .wr_o(wr)
  );

  nv_seq_match u_match (
    .clk_i, .rst_ni, .rd_evt_i(rd_evt), .wr_i(wr),
    .key_i(key), .cmd_o(cmd)
  );

  nv_cmd_out u_out (
    .clk_i, .rst_ni, .cmd_i(cmd), .ce_ni, .oe_ni,
    .store_o, .recall_o, .as_en_o, .as_dis_o, .as_enabled_o, .dq_hiz_o
  );
endmodule

// File: rtl/nv_seq_det_chk.sv
module nv_seq_det_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic ce_ni,
  input logic we_ni,
  input logic store_o,
  input logic recall_o,
  input logic as_en_o,
  input logic as_dis_o,
  input logic as_enabled_o,
  input logic dq_hiz_o
);
  p_onehot_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({store_o, recall_o, as_en_o, as_dis_o}));

  p_single_store_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_o |=> !store_o);

  p_single_recall_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recall_o |=> !recall_o);

  p_write_blocks_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_ni && !we_ni) |=> !(store_o || recall_o || as_en_o || as_dis_o));

  p_as_on_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    as_en_o |-> as_enabled_o);

  p_as_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    as_dis_o |-> !as_enabled_o);

  p_as_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!as_en_o && !as_dis_o) |-> $stable(as_enabled_o));

  p_nv_float_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (store_o || recall_o) |-> dq_hiz_o);
endmodule

bind nv_cmd_seq_det nv_seq_det_chk u_chk (
  .clk_i, .rst_ni, .ce_ni, .we_ni, .store_o, .recall_o,
  .as_en_o, .as_dis_o, .as_enabled_o, .dq_hiz_o
);

// File: tb/tb_nv_cmd_seq_det.sv
module tb_nv_cmd_seq_det;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ce_ni = 1'b1, we_ni = 1'b1, oe_ni = 1'b0;
  logic [16:0] addr_i = '0;
  logic store_o, recall_o, as_en_o, as_dis_o, as_enabled_o, dq_hiz_o;

  int checks = 0, failures = 0;

  nv_cmd_seq_det dut (.*);

  always #5ns clk_i = ~clk_i;

  // bench reference state
  int          m_step;
  logic        m_ce, m_we, m_hold, m_asen;
  logic [15:0] m_key;
  logic [3:0]  m_pulse; // {store, recall, as_on, as_off}

  function automatic logic [15:0] pat(input int i);
    case (i)
      0: return 16'h4E38; 1: return 16'hB1C7; 2: return 16'h83E0;
      3: return 16'h7C1F; default: return 16'h703F;
    endcase
  endfunction

  function automatic logic [3:0] code_of(input logic [15:0] k);
    case (k)
      16'h8FC0: return 4'b1000;
      16'h4C63: return 4'b0100;
      16'h4B46: return 4'b0010;
      16'h8B45: return 4'b0001;
      default:  return 4'b0000;
    endcase
  endfunction

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_step = 0; m_ce = 1; m_we = 1; m_hold = 0; m_asen = 1; m_key = '0; m_pulse = '0;
  endtask

  task automatic cyc(input logic ce, input logic we, input logic oe, input logic [16:0] a);
    logic evt, wr;
    int   rs;
    ce_ni = ce; we_ni = we; oe_ni = oe; addr_i = a;
    evt = !ce && we && (m_ce || !m_we || a[15:0] != m_key);
    wr  = !ce && !we;
    rs  = (a[15:0] == pat(0)) ? 1 : 0;
    m_pulse = '0;
    if (wr) m_step = 0;
    else if (evt) begin
      if (m_step == 5) begin m_pulse = code_of(a[15:0]); m_step = rs; end
      else if (a[15:0] == pat(m_step)) m_step++;
      else m_step = rs;
    end
    if (m_pulse[1]) m_asen = 1;
    if (m_pulse[0]) m_asen = 0;
    if (m_pulse[3] || m_pulse[2]) m_hold = 1;
    else if (ce) m_hold = 0;
    m_ce = ce; m_we = we; m_key = a[15:0];
    @(negedge clk_i);
    chk(store_o,      m_pulse[3], "R4 store_o");
    chk(recall_o,     m_pulse[2], "R4 recall_o");
    chk(as_en_o,      m_pulse[1], "R5 as_en_o");
    chk(as_dis_o,     m_pulse[0], "R5 as_dis_o");
    chk(as_enabled_o, m_asen,     "R5 as_enabled_o");
    chk(dq_hiz_o,     ce | oe | m_hold, "R10 dq_hiz_o");
  endtask

  task automatic rd(input logic [16:0] a);
    cyc(1'b1, 1'b1, 1'b0, a);
    cyc(1'b0, 1'b1, 1'b0, a);
  endtask

  task automatic prefix(input logic top);
    for (int i = 0; i < 5; i++) rd({top, pat(i)});
  endtask

  initial begin
    #2_000_000ns;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk(store_o | recall_o | as_en_o | as_dis_o, 1'b0, "R1 pulses idle");
    chk(as_enabled_o, 1'b1, "R1 status enabled");
    chk(dq_hiz_o, 1'b1, "R1 deselected floats");

    // R3 R4 store, then float hold R10
    prefix(1'b0); rd(17'h08FC0);
    chk(store_o, 1'b1, "R4 store fired");
    chk(dq_hiz_o, 1'b1, "R10 hold after store");
    cyc(1'b0, 1'b1, 1'b0, 17'h00123);
    chk(dq_hiz_o, 1'b1, "R10 hold while selected");
    cyc(1'b1, 1'b1, 1'b0, 17'h00123);
    cyc(1'b0, 1'b1, 1'b0, 17'h00124);
    chk(dq_hiz_o, 1'b0, "R10 hold cleared by deselect");

    // R4 recall
    prefix(1'b0); rd(17'h04C63);
    chk(recall_o, 1'b1, "R4 recall fired");

    // R5 disable then enable, R10 no hold
    prefix(1'b0); rd(17'h08B45);
    chk(as_dis_o, 1'b1, "R5 disable fired");
    chk(as_enabled_o, 1'b0, "R5 status cleared");
    chk(dq_hiz_o, 1'b0, "R10 as command keeps data active");
    prefix(1'b0); rd(17'h04B46);
    chk(as_en_o, 1'b1, "R5 enable fired");
    chk(as_enabled_o, 1'b1, "R5 status set");

    // R6 top address bit ignored
    rd(17'h10000 | pat(0)); rd({1'b0, pat(1)}); rd(17'h10000 | pat(2));
    rd({1'b1, pat(3)}); rd({1'b1, pat(4)}); rd(17'h18FC0);
    chk(store_o, 1'b1, "R6 store with bit16 set");

    // R7 write breaks the sequence
    rd({1'b0, pat(0)}); rd({1'b0, pat(1)}); rd({1'b0, pat(2)});
    cyc(1'b1, 1'b1, 1'b0, 17'h0); cyc(1'b0, 1'b0, 1'b0, 17'h00055);
    rd({1'b0, pat(3)}); rd({1'b0, pat(4)}); rd(17'h08FC0);
    chk(store_o, 1'b0, "R7 no store after write");

    // R8 interrupted then restarted via first address mid-sequence
    rd({1'b0, pat(0)}); rd({1'b0, pat(1)}); rd({1'b0, pat(0)});
    for (int i = 1; i < 5; i++) rd({1'b0, pat(i)});
    rd(17'h04C63);
    chk(recall_o, 1'b1, "R8 restart at step one");
    rd({1'b0, pat(0)}); rd({1'b0, pat(1)}); rd(17'h01234); rd({1'b0, pat(2)});
    rd({1'b0, pat(3)}); rd({1'b0, pat(4)}); rd(17'h04C63);
    chk(recall_o, 1'b0, "R8 mismatch restarts");

    // R11 unknown sixth address
    prefix(1'b0); rd(17'h01111);
    chk(store_o | recall_o | as_en_o | as_dis_o, 1'b0, "R11 unknown code");

    // R2 counting with CE held low, repeated address counted once
    cyc(1'b1, 1'b1, 1'b0, 17'h0);
    cyc(1'b0, 1'b1, 1'b0, {1'b0, pat(0)});
    cyc(1'b0, 1'b1, 1'b0, {1'b0, pat(1)});
    cyc(1'b0, 1'b1, 1'b0, {1'b0, pat(1)});
    cyc(1'b0, 1'b1, 1'b0, {1'b1, pat(1)});
    for (int i = 2; i < 5; i++) cyc(1'b0, 1'b1, 1'b0, {1'b0, pat(i)});
    cyc(1'b0, 1'b1, 1'b0, 17'h08B45);
    chk(as_dis_o, 1'b1, "R2 held read counted once");
    @(posedge clk_i); @(negedge clk_i);
    chk(as_dis_o, 1'b0, "R9 single-cycle pulse");
    cyc(1'b0, 1'b1, 1'b0, 17'h08B45);

    // constrained random traffic
    void'($urandom(32'h5eed_1234));
    for (int n = 0; n < 4000; n++) begin
      logic [16:0] a;
      int sel = $urandom_range(0, 9);
      if (sel < 5)      a = {1'($urandom), pat(m_step < 5 ? m_step : 0)};
      else if (sel < 8) begin
        case ($urandom_range(0, 3))
          0: a = 17'h08FC0; 1: a = 17'h04C63; 2: a = 17'h04B46; default: a = 17'h08B45;
        endcase
        a[16] = 1'($urandom);
      end else a = 17'($urandom);
      cyc(($urandom_range(0, 9) < 2), ($urandom_range(0, 19) != 0),
          ($urandom_range(0, 9) == 0), a);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule